// File: doc/BRIEF.md
# Host Byte-Lane Receive Register

This block gives an 8-bit host bus a narrow window onto a 24-bit receive word. The host writes the word one byte at a time into a small set of staging bytes. Each staging byte sits at its own address. Writing the low-order byte is the trigger: the block then forms the full word from the two upper staging bytes and the byte being written. It loads that word into a receive register on the DSP side and raises a valid flag. The window also holds one padding address. That address lets a 32-bit host store span the window cleanly. The padding address always reads as zero, and writes to it are dropped.

The DSP side is a valid/ready output stream. `rx_valid` rises in the cycle after a commit and stays high until the consumer asserts `rx_ready`. While `rx_valid` is high and no new commit arrives, `rx_word` does not change. A transfer completes on any clock edge where both `rx_valid` and `rx_ready` are high. There is no back-pressure toward the host: a commit while a word is still pending replaces that word. The host side is a plain register bus with a 3-bit address, an 8-bit data path and single-cycle read and write strobes. Reads are combinational.

With the default parameters, the window covers addresses 4 to 7:
- address 4 is padding;
- address 5 is the high byte (bits 23:16);
- address 6 is the middle byte (bits 15:8);
- address 7 is the low byte (bits 7:0) and commits the word.

Addresses 0 to 3 are outside the window.

Top module: `hbl_rx_window`

## Requirements
- R1: After synchronous reset, `rx_valid` is 0, `rx_word` is 0 and every staging byte reads back as 0x00.
- R2: A write to address 5 or 6 updates only the high (bits 23:16) or middle (bits 15:8) staging byte, which reads back at that address, and never raises `rx_valid`.
- R3: The padding address 4 reads 0x00; a write to it changes no staging byte and starts no transfer.
- R4: A write of byte D to address 7 makes `rx_word` equal {high staging, middle staging, D} and `rx_valid` 1 on the next cycle, and address 7 then reads D.
- R5: An 8- or 16-bit host store (low byte only, or middle then low) commits a word whose unwritten upper bytes keep their previous staging values.
- R6: Once high, `rx_valid` stays high until a clock edge where `rx_ready` is 1, and falls after that edge unless a commit occurs in the same cycle.
- R7: A commit while `rx_valid` is pending, with or without `rx_ready`, replaces `rx_word` with the new word and leaves `rx_valid` at 1.
- R8: Addresses 0 to 3 read 0x00 and writes to them change no state.
- R9: `host_rdata` is 0x00 in any cycle where `host_rd` is 0.
- R10: While `rx_valid` is 1 and no commit occurs, `rx_word` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 3 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Host read data, combinational, zero when not reading |
| rx_word | output | 24 | Committed receive word |
| rx_valid | output | 1 | Receive word pending |
| rx_ready | input | 1 | DSP side accepts the pending word |

## Verification
The bench builds the block with its default parameters: a 3-bit address, 8-bit bytes and three data lanes. With these values the entire host address space is only eight locations. A sweep can therefore write many data patterns to every address, inside and outside the window. After each write the bench reads back all eight addresses against an arithmetic model. This reaches every lane, the padding slot and every undecoded address. Directed sequences follow the sweep. They cover partial-width stores, holding a word under back-pressure, and commits that coincide with a pending word or an accept.

// File: rtl/hbl_pkg.sv
package hbl_pkg;
  // First address of the window: the window sits at the top of the address space.
  function automatic int win_base(input int addr_w, input int lanes);
    return (1 << addr_w) - lanes - 1;
  endfunction

  // Address of lane l (lane 0 is the least significant byte).
  function automatic int lane_addr(input int addr_w, input int lanes, input int l);
    return win_base(addr_w, lanes) + lanes - l;
  endfunction
endpackage

// File: rtl/hbl_addr_dec.sv
module hbl_addr_dec #(
  parameter int ADDR_W = 3,
  parameter int LANES  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [LANES-1:0]  lane_sel,
  output logic              pad_hit
);
  localparam int BASE = hbl_pkg::win_base(ADDR_W, LANES);

  always_comb begin
    pad_hit = (int'(addr) == BASE);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int LA = hbl_pkg::lane_addr(ADDR_W, LANES, l);
    assign lane_sel[l] = (int'(addr) == LA);
  end
endmodule

// File: rtl/hbl_stage.sv
module hbl_stage #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        lane_sel,
  input  logic [BYTE_W-1:0]       wdata,
  output logic [LANES*BYTE_W-1:0] stage
);
  for (genvar l = 0; l < LANES; l++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)
        stage[l*BYTE_W +: BYTE_W] <= '0;
      else if (wr_en && lane_sel[l])
        stage[l*BYTE_W +: BYTE_W] <= wdata;
    end
  end
endmodule

// File: rtl/hbl_rx_hold.sv
module hbl_rx_hold #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [WORD_W-1:0] word_in,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else if (commit) begin
      rx_word  <= word_in;
      rx_valid <= 1'b1;
    end else if (rx_valid && rx_ready) begin
      rx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hbl_rd_mux.sv
module hbl_rd_mux #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 3
) (
  input  logic                    rd,
  input  logic [LANES-1:0]        lane_sel,
  input  logic [LANES*BYTE_W-1:0] stage,
  output logic [BYTE_W-1:0]       rdata
);
  // AND-OR select: pad and undecoded addresses have no lane bit and yield zero.
  always_comb begin
    rdata = '0;
    for (int l = 0; l < LANES; l++) begin
      if (rd && lane_sel[l])
        rdata = rdata | stage[l*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/hbl_rx_window.sv
module hbl_rx_window #(
  parameter int ADDR_W = 3,
  parameter int BYTE_W = 8,
  parameter int LANES  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         host_addr,
  input  logic [BYTE_W-1:0]         host_wdata,
  input  logic                      host_wr,
  input  logic                      host_rd,
  output logic [BYTE_W-1:0]         host_rdata,
  output logic [LANES*BYTE_W-1:0]   rx_word,
  output logic                      rx_valid,
  input  logic                      rx_ready
);
  localparam int WORD_W = LANES * BYTE_W;

  logic [LANES-1:0]  lane_sel;
  logic              pad_hit;
  logic [WORD_W-1:0] stage;
  logic [WORD_W-1:0] word_in;
  logic              commit;

  hbl_addr_dec #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .addr     (host_addr),
    .lane_sel (lane_sel),
    .pad_hit  (pad_hit)
  );

  hbl_stage #(.BYTE_W(BYTE_W), .LANES(LANES)) u_stage (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (host_wr),
    .lane_sel (lane_sel),
    .wdata    (host_wdata),
    .stage    (stage)
  );

  // The low lane commits; its byte comes straight from the bus, upper lanes from staging.
  assign commit = host_wr && lane_sel[0] && !pad_hit;

  if (LANES > 1) begin : g_multi
    assign word_in = {stage[WORD_W-1:BYTE_W], host_wdata};
  end else begin : g_single
    assign word_in = host_wdata;
  end

  hbl_rx_hold #(.WORD_W(WORD_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .commit   (commit),
    .word_in  (word_in),
    .rx_ready (rx_ready),
    .rx_word  (rx_word),
    .rx_valid (rx_valid)
  );

  hbl_rd_mux #(.BYTE_W(BYTE_W), .LANES(LANES)) u_rd (
    .rd       (host_rd),
    .lane_sel (lane_sel),
    .stage    (stage),
    .rdata    (host_rdata)
  );
endmodule

// File: rtl/hbl_rx_window_chk.sv
module hbl_rx_window_chk #(
  parameter int ADDR_W = 3,
  parameter int BYTE_W = 8,
  parameter int LANES  = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic [ADDR_W-1:0]       host_addr,
  input logic                    host_wr,
  input logic                    host_rd,
  input logic [BYTE_W-1:0]       host_rdata,
  input logic [LANES*BYTE_W-1:0] rx_word,
  input logic                    rx_valid,
  input logic                    rx_ready
);
  localparam int PAD_A = hbl_pkg::win_base(ADDR_W, LANES);
  localparam int LOW_A = hbl_pkg::lane_addr(ADDR_W, LANES, 0);

  logic wr_low;
  assign wr_low = host_wr && (int'(host_addr) == LOW_A);

  a_r4_commit_valid: assert property (@(posedge clk) disable iff (rst)
    wr_low |=> rx_valid);

  a_r6_hold_pending: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !rx_ready && !wr_low |=> rx_valid);

  a_r10_word_stable: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !wr_low |=> $stable(rx_word));

  a_r6_drop_on_accept: assert property (@(posedge clk) disable iff (rst)
    rx_valid && rx_ready && !wr_low |=> !rx_valid);

  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !rx_valid && !wr_low |=> !rx_valid);

  a_r3_pad_reads_zero: assert property (@(posedge clk) disable iff (rst)
    host_rd && (int'(host_addr) == PAD_A) |-> host_rdata == '0);

  a_r8_outside_zero: assert property (@(posedge clk) disable iff (rst)
    host_rd && (int'(host_addr) < PAD_A) |-> host_rdata == '0);

  a_r9_idle_rdata: assert property (@(posedge clk) disable iff (rst)
    !host_rd |-> host_rdata == '0);
endmodule

bind hbl_rx_window hbl_rx_window_chk #(
  .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LANES(LANES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_addr  (host_addr),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_rdata (host_rdata),
  .rx_word    (rx_word),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready)
);

// File: tb/sim_hbl_rx_window.sv
`timescale 1ns/1ps
module sim_hbl_rx_window;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_rdata;
  logic [23:0] rx_word;
  logic        rx_valid;
  logic        rx_ready = 1'b0;

  int n_run = 0;
  int n_fail = 0;

  // Bench model: lane 0 = low (addr 7), 1 = middle (addr 6), 2 = high (addr 5).
  logic [7:0]  m_stg [3];
  logic [23:0] m_word;
  logic        m_valid;

  always #5 clk = ~clk;

  hbl_rx_window u0 (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .rx_word(rx_word), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input int a);
    if (a >= 5) return m_stg[7 - a];
    return 8'h00;
  endfunction

  // One host write with rx_ready held at rdy; model updated for that edge.
  task automatic wr(input int a, input logic [7:0] d, input logic rdy);
    @(negedge clk);
    host_addr = 3'(a); host_wdata = d; host_wr = 1'b1; rx_ready = rdy;
    @(negedge clk);
    host_wr = 1'b0; rx_ready = 1'b0;
    if (a == 7) begin
      m_word = {m_stg[2], m_stg[1], d};
      m_valid = 1'b1;
    end else if (m_valid && rdy) begin
      m_valid = 1'b0;
    end
    if (a >= 5) m_stg[7 - a] = d;
  endtask

  task automatic idle(input logic rdy);
    @(negedge clk);
    rx_ready = rdy;
    @(negedge clk);
    rx_ready = 1'b0;
    if (m_valid && rdy) m_valid = 1'b0;
  endtask

  task automatic rd_all(input string tag);
    for (int a = 0; a < 8; a++) begin
      host_addr = 3'(a); host_rd = 1'b1;
      #1;
      chk(tag, 32'(host_rdata), 32'(m_read(a)));
      host_rd = 1'b0;
      #1;
    end
  endtask

  task automatic chk_out(input string tag);
    chk({tag, " valid"}, 32'(rx_valid), 32'(m_valid));
    chk({tag, " word"}, 32'(rx_word), 32'(m_word));
  endtask

  initial begin
    for (int l = 0; l < 3; l++) m_stg[l] = 8'h00;
    m_word = '0; m_valid = 1'b0;
    // Preload garbage before reset so reset clearing is visible.
    repeat (2) @(negedge clk);
    rst = 1'b0;
    host_addr = 3'd5; host_wdata = 8'hEE; host_wr = 1'b1;
    @(negedge clk);
    host_addr = 3'd7;
    @(negedge clk);
    host_wr = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk_out("R1 reset");
    rd_all("R1 reset readback");

    // Sweep: every address, many data patterns; accept occasionally.
    for (int a = 0; a < 8; a++) begin
      for (int k = 0; k < 16; k++) begin
        logic [7:0] d;
        string tag;
        d = 8'((a * 53 + k * 29 + 7) & 255);
        tag = (a < 4) ? "R8 outside" : (a == 4) ? "R3 pad" : (a == 7) ? "R4 commit" : "R2 stage";
        wr(a, d, (k % 4) == 3);
        chk_out(tag);
        rd_all(tag);
        if ((k % 5) == 4) begin
          idle(1'b1);
          chk_out("R6 accept");
        end
      end
    end

    // R5: full 24-bit store, then 8-bit and 16-bit stores.
    idle(1'b1);
    wr(5, 8'h12, 1'b0); wr(6, 8'h34, 1'b0); wr(7, 8'h56, 1'b0);
    chk_out("R5 full store");
    chk("R5 full word", 32'(rx_word), 32'h123456);
    idle(1'b1);
    wr(7, 8'h9A, 1'b0);
    chk("R5 8-bit keeps upper", 32'(rx_word), 32'h12349A);
    idle(1'b1);
    wr(6, 8'hBC, 1'b0); wr(7, 8'hDE, 1'b0);
    chk("R5 16-bit keeps high", 32'(rx_word), 32'h12BCDE);

    // R10 / R6: word pending without ready holds for several cycles.
    for (int i = 0; i < 4; i++) begin
      idle(1'b0);
      chk_out("R10 hold");
      chk("R6 hold valid", 32'(rx_valid), 32'd1);
    end
    idle(1'b1);
    chk("R6 drop after accept", 32'(rx_valid), 32'd0);

    // R7: commit while pending, and commit together with ready.
    wr(7, 8'h01, 1'b0);
    wr(7, 8'h02, 1'b0);
    chk("R7 overwrite word", 32'(rx_word), 32'h12BC02);
    chk("R7 overwrite valid", 32'(rx_valid), 32'd1);
    wr(7, 8'h03, 1'b1);
    chk("R7 commit with ready word", 32'(rx_word), 32'h12BC03);
    chk("R7 commit with ready valid", 32'(rx_valid), 32'd1);

    // R3: 32-bit store spanning pad..low keeps lower 24 bits.
    wr(4, 8'hFF, 1'b0); wr(5, 8'hA1, 1'b0); wr(6, 8'hB2, 1'b0); wr(7, 8'hC3, 1'b0);
    chk("R3 32-bit store", 32'(rx_word), 32'hA1B2C3);

    // R9: no read strobe gives zero even on a populated lane.
    @(negedge clk);
    host_addr = 3'd5; host_rd = 1'b0;
    #1;
    chk("R9 idle rdata", 32'(host_rdata), 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule